// File: doc/BRIEF.md
# Register-Triggered Semaphore Dispatcher

This block sits on a processor's register-access port and turns loads and stores to special trigger addresses into semaphore requests on a memory port. It serves a parameterised number of processor pairs (two by default). Each pair owns a control register with an enable ("armed") bit and a size bit, plus an operand-address register. Which trigger address is accessed picks the memory operation: one of three fetch variants, a noncoherent read, a noncoherent write or a coherent increment. The memory address always comes from the pair's operand-address register, never from the processor's access.

A trigger access goes to memory only when the pair is armed and the operand address suits the selected size. In every other case a read returns zero and a write is discarded. A misaligned armed access also raises a one-cycle error pulse. The block handles one memory request at a time. While that request is pending, the processor port is held off, and a read trigger's response waits for the memory response.

Address map (byte address): bits [5:3] select the slot, and bits starting at 6 select the pair. The slots are: 0 control, 1 operand address, 2 fetch-and-clear, 3 fetch-and-increment, 4 fetch-and-decrement, 5 noncoherent read, 6 noncoherent write, 7 coherent increment. All other address bits are ignored.

Top module: `sem_dispatch`

## Requirements
- R1: After reset, every pair is disarmed with size 0 and operand address 0, `cpu_req_ready` is 1, and `mem_req_valid`, `cpu_rsp_valid` and `err_misalign` are 0.
- R2: A write to slot 0 of a pair sets armed from `wdata[0]` and size from `wdata[1]`. A write to slot 1 sets the operand address from `wdata[MAW-1:0]`. Reads of slot 0 and slot 1 return these values zero-extended, with `cpu_rsp_valid` one cycle after acceptance. Writes to one pair leave every other pair unchanged.
- R3: An armed read of slots 2, 3 or 4 issues one request with kind 0. Its fop is 0 (clear), 1 (increment) or 2 (decrement), its dword bit equals the pair's size bit, and its address is the pair's operand address. `mem_req_pair` carries the pair index. The memory response data is returned to the processor.
- R4: An armed read of slot 5 issues a request with kind 1, with dword taken from `cpu_req_dword`. The read data is returned on `cpu_rsp_rdata` with `cpu_rsp_valid` one cycle after the `mem_rsp_valid` cycle.
- R5: An armed write to slot 6 issues a request with kind 2, dword taken from `cpu_req_dword`, and `mem_req_wdata` equal to the written data. No processor response is produced.
- R6: An armed write to slot 7 issues a request with kind 3 and dword equal to the size bit. `mem_req_wdata` is 0 and no processor response is produced.
- R7: A read trigger while unarmed issues no request and returns 0 one cycle after acceptance.
- R8: A write trigger while unarmed issues no request and produces no response.
- R9: A word operation needs operand-address bits [1:0] to be 0, and a double-word operation needs bits [2:0] to be 0. An armed misaligned trigger behaves as in R7/R8 and pulses `err_misalign` one cycle after acceptance.
- R10: From the acceptance of a memory trigger until the cycle after `mem_rsp_valid`, `cpu_req_ready` is 0. `mem_req_valid` and the request fields stay stable until `mem_req_ready`.
- R11: A write to a read slot (2 to 5) is discarded with no request. A read of a write slot (6, 7) returns 0 with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor access request |
| cpu_req_ready | output | 1 | Block can accept an access |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | CAW | Byte address of the access |
| cpu_req_wdata | input | DW | Store data |
| cpu_req_dword | input | 1 | Access size for slots 5 and 6: 1 = double word |
| cpu_rsp_valid | output | 1 | Load data valid pulse |
| cpu_rsp_rdata | output | DW | Load data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_kind | output | 2 | 0 fetch, 1 noncoherent read, 2 noncoherent write, 3 coherent increment |
| mem_req_fop | output | 2 | Fetch variant: 0 clear, 1 increment, 2 decrement |
| mem_req_pair | output | PB | Requesting pair index |
| mem_req_addr | output | MAW | Memory address |
| mem_req_dword | output | 1 | 1 = double-word operation |
| mem_req_wdata | output | DW | Write data (noncoherent write) |
| mem_rsp_valid | input | 1 | Memory completion, at least one cycle after the request handshake |
| mem_rsp_rdata | input | DW | Memory read data |
| err_misalign | output | 1 | Misaligned armed trigger pulse |

## Verification
Local results are due on the first cycle after the accepting edge: the response to a register read or to a suppressed read, and the error pulse. The memory request appears in that same cycle. The read response for a memory operation is due one cycle after the cycle in which `mem_rsp_valid` is high. The bench drives and samples on falling edges. Its memory model holds off `mem_req_ready` for one extra cycle, so the hold and back-pressure checks run at fixed points inside each transaction. Every expected outcome, including whether a request or a response appears at all, is read from the sample taken at exactly those cycles.

// File: rtl/sem_pkg.sv
package sem_pkg;
   localparam int SLOT_LSB = 3;
   localparam int SLOT_W   = 3;
   localparam int PAIR_LSB = SLOT_LSB + SLOT_W;

   typedef enum logic [2:0] {
      SL_CTRL = 3'd0, SL_OPND = 3'd1, SL_FCLR = 3'd2, SL_FINC = 3'd3,
      SL_FDEC = 3'd4, SL_NCRD = 3'd5, SL_NCWR = 3'd6, SL_CINC = 3'd7
   } slot_e;

   typedef enum logic [1:0] {
      K_FETCH = 2'd0, K_NCRD = 2'd1, K_NCWR = 2'd2, K_CINC = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WAIT = 2'd2
   } seq_st_e;
endpackage

// File: rtl/sem_ctx_bank.sv
module sem_ctx_bank #(
   parameter int NUM_PAIRS = 2,
   parameter int MAW       = 32,
   parameter int DW        = 64,
   localparam int PB       = $clog2(NUM_PAIRS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [PB-1:0]                     wr_pair,
   input  logic                              wr_opnd,
   input  logic [DW-1:0]                     wr_data,
   output logic [NUM_PAIRS-1:0]              armed,
   output logic [NUM_PAIRS-1:0]              dsize,
   output logic [NUM_PAIRS-1:0][MAW-1:0]     opnd
);
   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic           arm_q;
      logic           size_q;
      logic [MAW-1:0] opnd_q;
      logic           sel;

      assign sel = wr_en && (wr_pair == PB'(p));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            arm_q  <= 1'b0;
            size_q <= 1'b0;
            opnd_q <= '0;
         end else if (sel) begin
            if (wr_opnd) opnd_q <= wr_data[MAW-1:0];
            else begin
               arm_q  <= wr_data[0];
               size_q <= wr_data[1];
            end
         end
      end

      assign armed[p] = arm_q;
      assign dsize[p] = size_q;
      assign opnd[p]  = opnd_q;
   end

   // R2: registers only change on a register write
   p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(armed) && $stable(dsize) && $stable(opnd));
endmodule

// File: rtl/sem_decode.sv
module sem_decode
   import sem_pkg::*;
#(
   parameter int NUM_PAIRS = 2,
   parameter int MAW       = 32,
   parameter int DW        = 64,
   parameter int CAW       = 12,
   localparam int PB       = $clog2(NUM_PAIRS)
) (
   input  logic                          write,
   input  logic [CAW-1:0]                addr,
   input  logic                          req_dword,
   input  logic [NUM_PAIRS-1:0]          armed,
   input  logic [NUM_PAIRS-1:0]          dsize,
   input  logic [NUM_PAIRS-1:0][MAW-1:0] opnd,
   output logic [PB-1:0]                 pair,
   output logic                          trig,
   output logic                          go,
   output logic                          misalign,
   output logic                          reg_wr,
   output logic                          reg_opnd,
   output kind_e                         kind,
   output logic [1:0]                    fop,
   output logic                          dword,
   output logic [MAW-1:0]                maddr,
   output logic [DW-1:0]                 local_data
);
   slot_e slot;
   logic  aligned;

   assign pair  = addr[PAIR_LSB +: PB];
   assign slot  = slot_e'(addr[SLOT_LSB +: SLOT_W]);
   assign maddr = opnd[pair];

   always_comb begin
      trig       = 1'b0;
      kind       = K_FETCH;
      fop        = 2'd0;
      dword      = dsize[pair];
      local_data = '0;
      unique case (slot)
         SL_CTRL: local_data = DW'({dsize[pair], armed[pair]});
         SL_OPND: local_data = DW'(opnd[pair]);
         SL_FCLR: begin trig = !write; fop = 2'd0; end
         SL_FINC: begin trig = !write; fop = 2'd1; end
         SL_FDEC: begin trig = !write; fop = 2'd2; end
         SL_NCRD: begin trig = !write; kind = K_NCRD; dword = req_dword; end
         SL_NCWR: begin trig = write;  kind = K_NCWR; dword = req_dword; end
         SL_CINC: begin trig = write;  kind = K_CINC; end
      endcase
      aligned = dword ? (maddr[2:0] == 3'd0) : (maddr[1:0] == 2'd0);
   end

   assign go       = trig && armed[pair] && aligned;
   assign misalign = trig && armed[pair] && !aligned;
   assign reg_wr   = write && (slot == SL_CTRL || slot == SL_OPND);
   assign reg_opnd = (slot == SL_OPND);
endmodule

// File: rtl/sem_seq.sv
module sem_seq
   import sem_pkg::*;
#(
   parameter int NUM_PAIRS = 2,
   parameter int MAW       = 32,
   parameter int DW        = 64,
   localparam int PB       = $clog2(NUM_PAIRS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic            is_read,
   input  logic            go,
   input  logic            misalign,
   input  kind_e           kind,
   input  logic [1:0]      fop,
   input  logic            dword,
   input  logic [PB-1:0]   pair,
   input  logic [MAW-1:0]  maddr,
   input  logic [DW-1:0]   wdata,
   input  logic [DW-1:0]   local_data,
   output logic            busy,
   output logic            cpu_rsp_valid,
   output logic [DW-1:0]   cpu_rsp_rdata,
   output logic            err_misalign,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [1:0]      mem_req_kind,
   output logic [1:0]      mem_req_fop,
   output logic [PB-1:0]   mem_req_pair,
   output logic [MAW-1:0]  mem_req_addr,
   output logic            mem_req_dword,
   output logic [DW-1:0]   mem_req_wdata,
   input  logic            mem_rsp_valid,
   input  logic [DW-1:0]   mem_rsp_rdata
);
   seq_st_e st_q;
   logic    rd_pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q          <= ST_IDLE;
         rd_pend_q     <= 1'b0;
         cpu_rsp_valid <= 1'b0;
         cpu_rsp_rdata <= '0;
         err_misalign  <= 1'b0;
         mem_req_kind  <= '0;
         mem_req_fop   <= '0;
         mem_req_pair  <= '0;
         mem_req_addr  <= '0;
         mem_req_dword <= 1'b0;
         mem_req_wdata <= '0;
      end else begin
         cpu_rsp_valid <= 1'b0;
         err_misalign  <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (accept) begin
               err_misalign <= misalign;
               if (go) begin
                  st_q          <= ST_REQ;
                  rd_pend_q     <= is_read;
                  mem_req_kind  <= kind;
                  mem_req_fop   <= (kind == K_FETCH) ? fop : 2'd0;
                  mem_req_pair  <= pair;
                  mem_req_addr  <= maddr;
                  mem_req_dword <= dword;
                  mem_req_wdata <= (kind == K_NCWR) ? wdata : '0;
               end else if (is_read) begin
                  cpu_rsp_valid <= 1'b1;
                  cpu_rsp_rdata <= local_data;
               end
            end
            ST_REQ:  if (mem_req_ready) st_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               st_q <= ST_IDLE;
               if (rd_pend_q) begin
                  cpu_rsp_valid <= 1'b1;
                  cpu_rsp_rdata <= mem_rsp_rdata;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (st_q != ST_IDLE);
   assign mem_req_valid = (st_q == ST_REQ);

   // R10: request held stable until taken
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_kind) && $stable(mem_req_wdata));
   // R3: fop only meaningful for fetch requests
   p_fop_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_kind != K_FETCH |-> mem_req_fop == 2'd0);
   // R6: only the noncoherent write carries data
   p_wdata_ncwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_kind != K_NCWR |-> mem_req_wdata == '0);
   // R4: read data forwarded one cycle after memory completion
   p_rsp_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_WAIT && mem_rsp_valid && rd_pend_q |=>
         cpu_rsp_valid && cpu_rsp_rdata == $past(mem_rsp_rdata));
   // R9: misaligned access never leaves a request pending
   p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_misalign |-> st_q == ST_IDLE);
endmodule

// File: rtl/sem_dispatch.sv
module sem_dispatch
   import sem_pkg::*;
#(
   parameter int NUM_PAIRS = 2,
   parameter int MAW       = 32,
   parameter int DW        = 64,
   parameter int CAW       = 12,
   localparam int PB       = $clog2(NUM_PAIRS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_req_valid,
   output logic            cpu_req_ready,
   input  logic            cpu_req_write,
   input  logic [CAW-1:0]  cpu_req_addr,
   input  logic [DW-1:0]   cpu_req_wdata,
   input  logic            cpu_req_dword,
   output logic            cpu_rsp_valid,
   output logic [DW-1:0]   cpu_rsp_rdata,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [1:0]      mem_req_kind,
   output logic [1:0]      mem_req_fop,
   output logic [PB-1:0]   mem_req_pair,
   output logic [MAW-1:0]  mem_req_addr,
   output logic            mem_req_dword,
   output logic [DW-1:0]   mem_req_wdata,
   input  logic            mem_rsp_valid,
   input  logic [DW-1:0]   mem_rsp_rdata,
   output logic            err_misalign
);
   if (NUM_PAIRS < 2 || (NUM_PAIRS & (NUM_PAIRS - 1)) != 0) begin : g_bad_pairs
      $error("NUM_PAIRS must be a power of two, at least 2");
   end
   if (DW < 64) begin : g_bad_dw
      $error("DW must hold a double word");
   end
   if (MAW < 3 || MAW > DW) begin : g_bad_maw
      $error("MAW must be between 3 and DW");
   end
   if (CAW < PAIR_LSB + PB) begin : g_bad_caw
      $error("CAW too narrow for the trigger map");
   end

   logic [NUM_PAIRS-1:0]          armed, dsize;
   logic [NUM_PAIRS-1:0][MAW-1:0] opnd;
   logic [PB-1:0]                 pair;
   logic                          trig, go, misalign, reg_wr, reg_opnd, dword, busy, accept;
   kind_e                         kind;
   logic [1:0]                    fop;
   logic [MAW-1:0]                maddr;
   logic [DW-1:0]                 local_data;
   logic                          unused_addr;

   assign unused_addr   = ^cpu_req_addr;
   assign cpu_req_ready = !busy;
   assign accept        = cpu_req_valid && cpu_req_ready;

   sem_ctx_bank #(.NUM_PAIRS(NUM_PAIRS), .MAW(MAW), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(accept && reg_wr), .wr_pair(pair),
      .wr_opnd(reg_opnd), .wr_data(cpu_req_wdata),
      .armed(armed), .dsize(dsize), .opnd(opnd));

   sem_decode #(.NUM_PAIRS(NUM_PAIRS), .MAW(MAW), .DW(DW), .CAW(CAW)) u_dec (
      .write(cpu_req_write), .addr(cpu_req_addr), .req_dword(cpu_req_dword),
      .armed(armed), .dsize(dsize), .opnd(opnd), .pair(pair), .trig(trig),
      .go(go), .misalign(misalign), .reg_wr(reg_wr), .reg_opnd(reg_opnd),
      .kind(kind), .fop(fop), .dword(dword), .maddr(maddr), .local_data(local_data));

   sem_seq #(.NUM_PAIRS(NUM_PAIRS), .MAW(MAW), .DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .accept(accept), .is_read(!cpu_req_write),
      .go(go), .misalign(misalign), .kind(kind), .fop(fop), .dword(dword),
      .pair(pair), .maddr(maddr), .wdata(cpu_req_wdata), .local_data(local_data),
      .busy(busy), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
      .err_misalign(err_misalign), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_kind(mem_req_kind),
      .mem_req_fop(mem_req_fop), .mem_req_pair(mem_req_pair),
      .mem_req_addr(mem_req_addr), .mem_req_dword(mem_req_dword),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata));

   // R7 / R8: an unarmed trigger never reaches memory
   p_unarmed_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept && trig && !armed[pair] |=> !mem_req_valid && !err_misalign);
   // R10: no new access while a request is outstanding
   p_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !cpu_req_ready);
   // R3: a memory request uses the pair's operand address
   p_addr_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept && go |=> mem_req_valid && mem_req_addr == $past(maddr));
endmodule

// File: tb/tb_sem_dispatch.sv
module tb_sem_dispatch;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0, cpu_req_dword = 1'b0;
   logic [11:0] cpu_req_addr = '0;
   logic [63:0] cpu_req_wdata = '0;
   logic        cpu_req_ready, cpu_rsp_valid, mem_req_valid, mem_req_dword, err_misalign;
   logic [63:0] cpu_rsp_rdata, mem_req_wdata;
   logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_rdata = '0;
   logic [1:0]  mem_req_kind, mem_req_fop;
   logic [0:0]  mem_req_pair;
   logic [31:0] mem_req_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   sem_dispatch dut (.*);

   int checks = 0, errors = 0;
   bit done = 0;

   typedef struct packed {
      logic wr; logic [11:0] addr; logic [63:0] wd; logic dw;
      logic xreq; logic [1:0] xk; logic [1:0] xf; logic xdw; logic [31:0] xa;
      logic xrsp; logic [63:0] xd; logic xerr; logic [3:0] rq;
   } vec_t;

   // slot addresses: pair0 base 0x000, pair1 base 0x040, slot n at n*8
   localparam logic [11:0] CTL0=12'h000, OPN0=12'h008, FCL0=12'h010, FIN0=12'h018,
      FDE0=12'h020, NRD0=12'h028, NWR0=12'h030, CIN0=12'h038,
      CTL1=12'h040, OPN1=12'h048, FDE1=12'h060;
   localparam int NV = 41;
   localparam vec_t VECS [NV] = '{
      '{0,CTL0,64'h0,0, 0,0,0,0,32'h0,    1,64'h0,0, 1}, // R1 reset ctrl
      '{0,FCL0,64'h0,0, 0,0,0,0,32'h0,    1,64'h0,0, 7}, // R7
      '{0,NRD0,64'h0,0, 0,0,0,0,32'h0,    1,64'h0,0, 7}, // R7
      '{1,NWR0,64'h55,0,0,0,0,0,32'h0,    0,64'h0,0, 8}, // R8
      '{1,CIN0,64'h0,0, 0,0,0,0,32'h0,    0,64'h0,0, 8}, // R8
      '{1,OPN0,64'h1000,0,0,0,0,0,32'h0,  0,64'h0,0, 2}, // R2
      '{1,CTL0,64'h1,0, 0,0,0,0,32'h0,    0,64'h0,0, 2},
      '{0,CTL0,64'h0,0, 0,0,0,0,32'h0,    1,64'h1,0, 2},
      '{0,OPN0,64'h0,0, 0,0,0,0,32'h0,    1,64'h1000,0, 2},
      '{0,CTL1,64'h0,0, 0,0,0,0,32'h0,    1,64'h0,0, 2},
      '{0,FCL0,64'h0,0, 1,0,0,0,32'h1000, 1,64'h0,0, 3}, // R3 clear
      '{0,FIN0,64'h0,0, 1,0,1,0,32'h1000, 1,64'h0,0, 3},
      '{0,FDE0,64'h0,0, 1,0,2,0,32'h1000, 1,64'h0,0, 3},
      '{0,NRD0,64'h0,0, 1,1,0,0,32'h1000, 1,64'h0,0, 4}, // R4
      '{1,NWR0,64'hDEADBEEF00000011,0, 1,2,0,0,32'h1000, 0,64'h0,0, 5}, // R5
      '{1,CIN0,64'h9,0, 1,3,0,0,32'h1000, 0,64'h0,0, 6}, // R6
      '{0,NRD0,64'h0,1, 1,1,0,1,32'h1000, 1,64'h0,0, 4},
      '{1,OPN0,64'h1004,0,0,0,0,0,32'h0,  0,64'h0,0, 2},
      '{0,NRD0,64'h0,1, 0,0,0,0,32'h0,    1,64'h0,1, 9}, // R9 dword misaligned
      '{0,NRD0,64'h0,0, 1,1,0,0,32'h1004, 1,64'h0,0, 9}, // R9 word ok
      '{1,CTL0,64'h3,0, 0,0,0,0,32'h0,    0,64'h0,0, 2},
      '{0,FCL0,64'h0,0, 0,0,0,0,32'h0,    1,64'h0,1, 9},
      '{1,CIN0,64'h0,0, 0,0,0,0,32'h0,    0,64'h0,1, 9},
      '{1,OPN0,64'h1008,0,0,0,0,0,32'h0,  0,64'h0,0, 2},
      '{0,FIN0,64'h0,0, 1,0,1,1,32'h1008, 1,64'h0,0, 3},
      '{1,CIN0,64'h0,0, 1,3,0,1,32'h1008, 0,64'h0,0, 6},
      '{1,NWR0,64'h0123456789ABCDEF,1, 1,2,0,1,32'h1008, 0,64'h0,0, 5},
      '{1,FCL0,64'h7,0, 0,0,0,0,32'h0,    0,64'h0,0, 11}, // R11
      '{0,NWR0,64'h0,0, 0,0,0,0,32'h0,    1,64'h0,0, 11},
      '{0,CIN0,64'h0,0, 0,0,0,0,32'h0,    1,64'h0,0, 11},
      '{1,OPN1,64'h2000,0,0,0,0,0,32'h0,  0,64'h0,0, 2},
      '{1,CTL1,64'h1,0, 0,0,0,0,32'h0,    0,64'h0,0, 2},
      '{0,FDE1,64'h0,0, 1,0,2,0,32'h2000, 1,64'h0,0, 3},
      '{0,OPN0,64'h0,0, 0,0,0,0,32'h0,    1,64'h1008,0, 2},
      '{1,CTL0,64'h0,0, 0,0,0,0,32'h0,    0,64'h0,0, 2},
      '{0,FIN0,64'h0,0, 0,0,0,0,32'h0,    1,64'h0,0, 7},
      '{1,NWR0,64'h1,0, 0,0,0,0,32'h0,    0,64'h0,0, 8},
      '{1,OPN0,64'h1002,0,0,0,0,0,32'h0,  0,64'h0,0, 2},
      '{1,CTL0,64'h1,0, 0,0,0,0,32'h0,    0,64'h0,0, 2},
      '{1,CIN0,64'h0,0, 0,0,0,0,32'h0,    0,64'h0,1, 9}, // R9 word misaligned
      '{0,FCL0,64'h0,0, 0,0,0,0,32'h0,    1,64'h0,1, 9}
   };

   function automatic logic [63:0] memd(input logic [31:0] a);
      return {32'hC0DE5EED, a};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   logic        g_req, g_rsp, g_err, g_dw, g_pair;
   logic [1:0]  g_k, g_f;
   logic [31:0] g_a;
   logic [63:0] g_wd, g_rd;

   task automatic access(input logic wr, input logic [11:0] a, input logic [63:0] wd,
                         input logic dw);
      g_req = 0; g_rsp = 0; g_rd = '0;
      @(negedge clk);
      cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a;
      cpu_req_wdata = wd; cpu_req_dword = dw;
      while (!cpu_req_ready) @(negedge clk);
      @(negedge clk);
      cpu_req_valid = 0;
      g_err = err_misalign;
      if (cpu_rsp_valid) begin g_rsp = 1; g_rd = cpu_rsp_rdata; end
      if (mem_req_valid) begin
         g_req = 1; g_k = mem_req_kind; g_f = mem_req_fop; g_a = mem_req_addr;
         g_dw = mem_req_dword; g_wd = mem_req_wdata; g_pair = mem_req_pair[0];
         chk(!cpu_req_ready, "R10", "ready low while busy", 64'(cpu_req_ready), 0);
         @(negedge clk);
         chk(mem_req_valid && mem_req_addr == g_a, "R10", "request held",
             64'(mem_req_addr), 64'(g_a));
         mem_req_ready = 1;
         @(negedge clk);
         mem_req_ready = 0;
         chk(!mem_req_valid && !cpu_req_ready, "R10", "waiting for response",
             {62'b0, mem_req_valid, cpu_req_ready}, 0);
         mem_rsp_valid = 1; mem_rsp_rdata = memd(g_a);
         @(negedge clk);
         mem_rsp_valid = 0;
         if (cpu_rsp_valid) begin g_rsp = 1; g_rd = cpu_rsp_rdata; end
         chk(cpu_req_ready, "R10", "ready after completion", 64'(cpu_req_ready), 1);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state at the ports
      chk(cpu_req_ready && !mem_req_valid && !cpu_rsp_valid && !err_misalign, "R1",
          "reset outputs", {60'b0, cpu_req_ready, mem_req_valid, cpu_rsp_valid, err_misalign},
          64'h8);
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string rq;
         logic [63:0] xd;
         v = VECS[i];
         rq = $sformatf("R%0d", v.rq);
         access(v.wr, v.addr, v.wd, v.dw);
         chk(g_req == v.xreq, rq, $sformatf("vec %0d request", i), 64'(g_req), 64'(v.xreq));
         if (g_req && v.xreq) begin
            chk({g_k, g_f, g_dw} == {v.xk, v.xf, v.xdw}, rq, $sformatf("vec %0d kind/fop/dword", i),
                64'({g_k, g_f, g_dw}), 64'({v.xk, v.xf, v.xdw}));
            chk(g_a == v.xa && g_pair == v.addr[6], rq, $sformatf("vec %0d addr/pair", i),
                {31'b0, g_pair, g_a}, {31'b0, v.addr[6], v.xa});
            chk(g_wd == ((v.xk == 2'd2) ? v.wd : 64'h0), rq, $sformatf("vec %0d wdata", i),
                g_wd, (v.xk == 2'd2) ? v.wd : 64'h0);
         end
         xd = v.xreq ? memd(v.xa) : v.xd;
         chk(g_rsp == v.xrsp, rq, $sformatf("vec %0d response", i), 64'(g_rsp), 64'(v.xrsp));
         if (g_rsp && v.xrsp)
            chk(g_rd == xd, rq, $sformatf("vec %0d rdata", i), g_rd, xd);
         chk(g_err == v.xerr, rq, $sformatf("vec %0d err", i), 64'(g_err), 64'(v.xerr));
      end

      // R1: reset while pair 0 is armed returns it to disarmed
      @(negedge clk);
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(cpu_req_ready && !mem_req_valid && !cpu_rsp_valid && !err_misalign, "R1",
          "outputs after second reset",
          {60'b0, cpu_req_ready, mem_req_valid, cpu_rsp_valid, err_misalign}, 64'h8);
      access(0, CTL0, 0, 0);
      chk(g_rsp && g_rd == 0, "R1", "ctrl cleared by reset", g_rd, 0);
      access(0, OPN0, 0, 0);
      chk(g_rsp && g_rd == 0, "R1", "operand cleared by reset", g_rd, 0);
      access(0, FCL0, 0, 0);
      chk(!g_req && g_rsp && g_rd == 0, "R1", "disarmed after reset",
          {62'b0, g_req, g_rsp}, 64'h1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule